// File: doc/BRIEF.md
# Vector Shift-Left-by-Immediate Execution Unit

This unit takes one 32-bit vector shift-by-immediate instruction word together with the 128-bit value of its source register. It decodes the word and, one clock later, presents the shifted vector, the destination register index, and either a result-valid or an illegal-encoding flag. The lane size and the shift count both come from one 7-bit immediate field. The position of the highest set bit in that field selects the lane size, and the bits below it give the count.

Two operations exist. The plain form shifts every lane of a 64-bit or 128-bit vector left. The widening form reads narrow lanes from either the lower or the upper half of the source, extends each lane to twice its width (signed or unsigned), and then shifts it. A widening shift by zero is therefore a plain sign or zero lengthen.

The unit accepts one word in every cycle in which `in_valid` is high. It has no back-pressure: there is no ready signal, the input is never refused, and the output must be taken in the cycle it appears.

Top module: `simd_shl_unit`

## Requirements
- R1: A word is legal only if bit 31 is 0, bits 28..23 equal 011110, bit 10 is 1, and bits 15..11 are either 01010 with bit 29 clear, or 10100. Every other accepted word raises `out_illegal` one cycle later and does not raise `out_valid`.
- R2: The immediate is bits 22..16. A highest set bit at position 3, 4, 5 or 6 of that field selects lanes of 8, 16, 32 or 64 bits. The bits below that highest set bit form the shift count, which lies in the range 0 to lane width minus 1.
- R3: The plain form (bits 15..11 = 01010) shifts each lane left by the count. Bits leaving a lane are lost and never enter the neighbouring lane.
- R4: In the plain form, bit 30 (Q) = 0 processes only the low 64 bits, and result bits 127..64 are zero. Q = 1 processes all 128 bits.
- R5: The widening form (bits 15..11 = 10100) extends each source lane to double width before the shift. Bit 29 = 0 selects sign extension and bit 29 = 1 selects zero extension. The result is 128 bits of double-width lanes: 8 to 16, 16 to 32, or 32 to 64 bits.
- R6: In the widening form, Q = 0 reads source bits 63..0 and Q = 1 reads source bits 127..64. The lowest lane of the selected half becomes result lane 0.
- R7: A widening shift with count 0 returns the extended source lanes unchanged.
- R8: An immediate whose bits 6..3 are all zero is illegal. An immediate with bit 6 set is illegal in the widening form. Either case raises `out_illegal` and suppresses `out_valid`.
- R9: `out_valid`, `out_result` and `out_rd` (instruction bits 4..0) appear exactly one cycle after a legal word is accepted. A word is accepted in every cycle with `in_valid` high.
- R10: `out_result` keeps its previous value after a cycle with `in_valid` low and after an illegal word. In both of those cases `out_valid` is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and source are presented this cycle |
| instr | input | 32 | Shift-by-immediate instruction word |
| src | input | 128 | Source register value |
| out_valid | output | 1 | Result of a legal word is present |
| out_result | output | 128 | Shifted vector |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | The word accepted last cycle was not a legal encoding |

## Verification
The unit holds no state across words except the output register, so a wrong internal decision shows up in the single cycle that follows the word that caused it. A wrong decode of the immediate shows as a wrong count or as a whole wrong lane grid. A wrong half selection or a wrong extension shows as wrong upper bits in widened lanes. A carry between lanes shows as stray low bits in the next lane up. The directed words put counts of 0 and lane width minus 1 on sources with set sign bits, so that each of these faults changes `out_result` at once. The random words then cover the remaining lane sizes, Q values and extension modes.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned VEC_W   = 128;
  localparam int unsigned NUM_SZ  = 4;

  localparam logic [4:0] OPC_PLAIN = 5'b01010;
  localparam logic [4:0] OPC_WIDEN = 5'b10100;
  localparam logic [5:0] CLASS_BITS = 6'b011110;

  typedef enum logic [1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic       legal;
    lane_sz_e   lsz;
    logic [5:0] count;
    logic       widen;
    logic       sext;
    logic       upper;
    logic [4:0] rd;
  } shl_op_t;

endpackage

// File: rtl/simd_shl_decode.sv
module simd_shl_decode
  import simd_shl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output shl_op_t            op_o
);

  logic [6:0] imm;
  logic [4:0] opc;
  logic       u_bit;
  logic       frame_ok;
  logic       is_plain;
  logic       is_widen;
  logic       size_ok;
  logic       unused_rn;

  assign imm       = instr_i[22:16];
  assign opc       = instr_i[15:11];
  assign u_bit     = instr_i[29];
  assign unused_rn = ^instr_i[9:5];

  assign frame_ok = (instr_i[31] == 1'b0) && (instr_i[28:23] == CLASS_BITS) && instr_i[10];
  assign is_plain = (opc == OPC_PLAIN) && !u_bit;
  assign is_widen = (opc == OPC_WIDEN);

  always_comb begin
    op_o.lsz   = LSZ_8;
    op_o.count = 6'd0;
    size_ok    = 1'b1;
    if (imm[6]) begin
      op_o.lsz   = LSZ_64;
      op_o.count = imm[5:0];
    end else if (imm[5]) begin
      op_o.lsz   = LSZ_32;
      op_o.count = {1'b0, imm[4:0]};
    end else if (imm[4]) begin
      op_o.lsz   = LSZ_16;
      op_o.count = {2'b0, imm[3:0]};
    end else if (imm[3]) begin
      op_o.lsz   = LSZ_8;
      op_o.count = {3'b0, imm[2:0]};
    end else begin
      size_ok = 1'b0;
    end
  end

  assign op_o.legal = frame_ok && size_ok &&
                      (is_plain || (is_widen && !imm[6]));
  assign op_o.widen = is_widen;
  assign op_o.sext  = !u_bit;
  assign op_o.upper = instr_i[30];
  assign op_o.rd    = instr_i[4:0];

endmodule

// File: rtl/simd_shl_lanes.sv
module simd_shl_lanes #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned VEC_W  = 128
) (
  input  logic [VEC_W-1:0]        vec_i,
  input  logic [VEC_W/2-1:0]      half_i,
  input  logic [$clog2(LANE_W)-1:0] count_i,
  input  logic                    sext_i,
  output logic [VEC_W-1:0]        plain_o,
  output logic [VEC_W-1:0]        wide_o
);

  localparam int unsigned N_PLAIN = VEC_W / LANE_W;
  localparam int unsigned HALF_W  = VEC_W / 2;
  localparam bit          CAN_WIDEN = (2 * LANE_W) <= HALF_W;

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    assign plain_o[i*LANE_W +: LANE_W] = vec_i[i*LANE_W +: LANE_W] << count_i;
  end

  if (CAN_WIDEN) begin : g_wide
    localparam int unsigned N_WIDE = HALF_W / LANE_W;
    for (genvar j = 0; j < N_WIDE; j++) begin : g_lane
      logic [LANE_W-1:0]   narrow;
      logic [2*LANE_W-1:0] ext;
      assign narrow = half_i[j*LANE_W +: LANE_W];
      assign ext    = {{LANE_W{sext_i & narrow[LANE_W-1]}}, narrow};
      assign wide_o[j*2*LANE_W +: 2*LANE_W] = ext << count_i;
    end
  end else begin : g_nowide
    logic unused_wide;
    assign unused_wide = ^{half_i, sext_i};
    assign wide_o = '0;
  end

endmodule

// File: rtl/simd_shl_unit.sv
module simd_shl_unit
  import simd_shl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        instr,
  input  logic [127:0]       src,
  output logic               out_valid,
  output logic [127:0]       out_result,
  output logic [4:0]         out_rd,
  output logic               out_illegal
);

  localparam int unsigned HALF_W = VEC_W / 2;

  shl_op_t            op;
  logic [HALF_W-1:0]  half_sel;
  logic [VEC_W-1:0]   plain_r [NUM_SZ];
  logic [VEC_W-1:0]   wide_r  [NUM_SZ];
  logic [VEC_W-1:0]   res_d;

  simd_shl_decode u_dec (
    .instr_i (instr),
    .op_o    (op)
  );

  assign half_sel = op.upper ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
    localparam int unsigned LW   = 8 << k;
    localparam int unsigned SH_W = $clog2(LW);
    simd_shl_lanes #(
      .LANE_W (LW),
      .VEC_W  (VEC_W)
    ) u_lanes (
      .vec_i   (src),
      .half_i  (half_sel),
      .count_i (op.count[SH_W-1:0]),
      .sext_i  (op.sext),
      .plain_o (plain_r[k]),
      .wide_o  (wide_r[k])
    );
  end

  always_comb begin
    res_d = op.widen ? wide_r[op.lsz] : plain_r[op.lsz];
    if (!op.widen && !op.upper) begin
      res_d[VEC_W-1:HALF_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
    end else begin
      out_valid   <= in_valid && op.legal;
      out_illegal <= in_valid && !op.legal;
      if (in_valid && op.legal) begin
        out_result <= res_d;
        out_rd     <= op.rd;
      end
    end
  end

endmodule

// File: rtl/simd_shl_unit_chk.sv
module simd_shl_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic         out_valid,
  input logic [127:0] out_result,
  input logic [4:0]   out_rd,
  input logic         out_illegal
);

  // R9: every accepted word yields exactly one of the two flags
  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_illegal}));

  a_r9_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid || out_illegal));

  // R10: no flag and no result change after an idle cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal && $stable(out_result)));

  // R8: empty lane-size field is illegal
  a_r8_empty_size: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[22:19] == 4'b0000) |=> (out_illegal && !out_valid));

  // R8: 64-bit lanes with the widening opcode are illegal
  a_r8_wide64: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[22] && instr[15:11] == 5'b10100) |=> out_illegal);

  // R4: a 64-bit plain shift leaves the upper half zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[30] && instr[15:11] == 5'b01010)
      |=> (out_illegal || out_result[127:64] == 64'd0));

  // R9: destination index follows the accepted word
  a_r9_rd_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_illegal || out_rd == $past(instr[4:0])));

  // R1: a broken fixed field never gives a valid result
  a_r1_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (instr[31] || !instr[10])) |=> !out_valid);

endmodule

bind simd_shl_unit simd_shl_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .instr       (instr),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_rd      (out_rd),
  .out_illegal (out_illegal)
);

// File: tb/simd_shl_unit_test.sv
module simd_shl_unit_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src = '0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [4:0]   out_rd;
  logic         out_illegal;

  int checks = 0;
  int fails  = 0;
  logic [127:0] held = '0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_shl_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .src(src),
    .out_valid(out_valid), .out_result(out_result), .out_rd(out_rd),
    .out_illegal(out_illegal)
  );

  function automatic logic [31:0] mk(bit q, bit u, logic [6:0] imm, logic [4:0] op,
                                     logic [4:0] rd);
    return {1'b0, q, u, 6'b011110, imm, op, 1'b1, 5'd3, rd};
  endfunction

  function automatic logic [6:0] mkimm(int w, int c);
    case (w)
      8:  return {4'b0001, 3'(c)};
      16: return {3'b001, 4'(c)};
      32: return {2'b01, 5'(c)};
      default: return {1'b1, 6'(c)};
    endcase
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [127:0] s,
                                output bit ok, output logic [127:0] r);
    logic [6:0] imm = ins[22:16];
    logic [4:0] op  = ins[15:11];
    bit q = ins[30];
    bit u = ins[29];
    int w, sh;
    bit plain, wid;
    logic [127:0] m1, m2, lane, h;
    w = 0; sh = 0;
    if (imm[6]) begin w = 64; sh = imm[5:0]; end
    else if (imm[5]) begin w = 32; sh = imm[4:0]; end
    else if (imm[4]) begin w = 16; sh = imm[3:0]; end
    else if (imm[3]) begin w = 8; sh = imm[2:0]; end
    plain = (op == 5'b01010) && !u;
    wid   = (op == 5'b10100);
    ok = !ins[31] && ins[28:23] == 6'b011110 && ins[10] && w != 0 &&
         (plain || (wid && w != 64));
    r = '0;
    if (!ok) return;
    m1 = {128{1'b1}} >> (128 - w);
    if (plain) begin
      for (int i = 0; i < (q ? 128 : 64) / w; i++) begin
        lane = (s >> (i * w)) & m1;
        lane = (lane << sh) & m1;
        r |= lane << (i * w);
      end
    end else begin
      m2 = {128{1'b1}} >> (128 - 2 * w);
      h = q ? (s >> 64) : (s & {64'd0, {64{1'b1}}});
      for (int i = 0; i < 64 / w; i++) begin
        lane = (h >> (i * w)) & m1;
        if (!u && ((lane >> (w - 1)) & 1) == 1) lane |= ~m1;
        lane = ((lane & m2) << sh) & m2;
        r |= lane << (i * 2 * w);
      end
    end
  endfunction

  task automatic check(bit cond, string req, string what, logic [127:0] act,
                       logic [127:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] ins, logic [127:0] s, string req);
    bit ok;
    logic [127:0] r;
    model(ins, s, ok, r);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src = s;
    @(negedge clk);
    in_valid = 1'b0;
    if (ok) begin
      held = r;
      check(out_valid && !out_illegal, req, "valid flag", {126'd0, out_valid, out_illegal}, 128'd2);
      check(out_result == r, req, "result", out_result, r);
      check(out_rd == ins[4:0], req, "rd", {123'd0, out_rd}, {123'd0, ins[4:0]});
    end else begin
      check(!out_valid && out_illegal, req, "illegal flag", {126'd0, out_valid, out_illegal}, 128'd1);
      check(out_result == held, req, "held result", out_result, held);
    end
  endtask

  logic [127:0] pat_a = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
  logic [127:0] pat_b = 128'hFFFF_0000_8000_7FFF_80FF_017F_8001_FE80;

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog expired actual=1 expected=0");
    fails++; checks++;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ws[4] = '{8, 16, 32, 64};
    repeat (3) @(negedge clk);
    check(!out_valid && !out_illegal && out_result == 0, "R9", "reset state",
          out_result, 128'd0);
    rst_n = 1'b1;

    foreach (ws[k]) begin
      int w = ws[k];
      // R3, R4: plain at both boundary counts and both widths
      apply(mk(0, 0, mkimm(w, 0), 5'b01010, 5'd1), pat_a, "R4");
      apply(mk(1, 0, mkimm(w, w - 1), 5'b01010, 5'd2), pat_a, "R3");
      apply(mk(0, 0, mkimm(w, w - 1), 5'b01010, 5'd4), pat_b, "R4");
      apply(mk(1, 0, mkimm(w, 1), 5'b01010, 5'd5), pat_b, "R3");
      if (w != 64) begin
        for (int q = 0; q < 2; q++)
          for (int u = 0; u < 2; u++) begin
            apply(mk(q[0], u[0], mkimm(w, 0), 5'b10100, 5'd6), pat_b, "R7");
            apply(mk(q[0], u[0], mkimm(w, w - 1), 5'b10100, 5'd7), pat_b, "R5");
            apply(mk(q[0], u[0], mkimm(w, w / 2), 5'b10100, 5'd8), pat_a, "R6");
          end
      end
    end

    // R8: illegal immediates
    apply(mk(1, 0, 7'b0000101, 5'b01010, 5'd9), pat_a, "R8");
    apply(mk(0, 1, 7'b1000011, 5'b10100, 5'd9), pat_a, "R8");
    // R1: broken fixed fields and unknown opcode, plain with U set
    apply(mk(1, 0, mkimm(8, 2), 5'b01010, 5'd9) | 32'h8000_0000, pat_a, "R1");
    apply(mk(1, 0, mkimm(8, 2), 5'b01010, 5'd9) & ~32'h0000_0400, pat_a, "R1");
    apply(mk(1, 0, mkimm(8, 2), 5'b01011, 5'd9), pat_a, "R1");
    apply(mk(1, 1, mkimm(8, 2), 5'b01010, 5'd9), pat_a, "R1");
    // R2: lane-size field decoded by leading one
    apply(mk(1, 0, 7'b0011111, 5'b01010, 5'd10), pat_b, "R2");

    // R10: idle cycle keeps the result and flags low
    @(negedge clk);
    check(!out_valid && !out_illegal && out_result == held, "R10", "idle hold",
          out_result, held);

    // Random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ins;
      logic [127:0] s;
      int w = ws[$urandom_range(3, 0)];
      int c = $urandom_range(w - 1, 0);
      bit wid = $urandom_range(1, 0);
      s = {$urandom, $urandom, $urandom, $urandom};
      ins = mk($urandom_range(1, 0), wid ? 1'($urandom_range(1, 0)) : 1'b0,
               mkimm(w, c), wid ? 5'b10100 : 5'b01010, 5'($urandom));
      if ($urandom_range(19, 0) == 0) ins = $urandom;
      apply(ins, s, "R2");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule